// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 active-high interrupt inputs and drives two active-low request lines toward a processor: a fast line and a normal line. Input 0 is wired to the fast line alone. Inputs 1 to 31 compete for the normal line by a programmable 3-bit priority. Each input has its own priority, a trigger type (level or rising edge) and a 32-bit vector word. Software reads a vector register to learn which handler to run. That read is also the acknowledge.

Each acknowledge of the normal line pushes the served priority onto a small in-service stack. While that level is in service, the normal line can only assert again for a strictly higher priority. A write to the end-of-service command pops one level, so that held-off requests of equal or lower priority get through. A read made while the line is not asserted returns a programmable spurious vector. The same happens when the winning request was masked in the cycle before the read.

Software reaches all state through a simple single-cycle register bus. Write data is taken in the cycle of the strobe. Read data appears on a registered output one cycle later.

Top module: `avic_top`

## Requirements
- R1: After a synchronous reset, nirq_o and nfiq_o are high, bus_rdata_o is zero, and the spurious word, masks, pending latches and in-service stack are all cleared.
- R2: Only input 0, when pending and enabled, drives nfiq_o low. Only inputs 1..31 drive nirq_o low. Both lines are registered and change one clock after the state that causes them.
- R3: A read of the normal vector word (address 0x40) returns the vector of the pending, enabled input among 1..31 with the highest priority. Priority ties go to the lower input number. The mode word at 0x00+n holds the priority in bits [2:0] (7 highest) and the trigger type in bit 4 (1 = rising edge). The vector word of input n is at 0x20+n.
- R4: A successful vector read deasserts nirq_o. The line asserts again only when the best pending priority is strictly above the top of the in-service stack. An input of higher priority pre-empts, and each acknowledge pushes a level.
- R5: A write to the end-of-service command (0x48) pops one in-service level. Requests of equal or lower priority that were held off then assert nirq_o again.
- R6: A read of the normal vector word while nirq_o is high, or while the winning request was withdrawn (for example masked) in the previous cycle, returns the spurious word at 0x49. Reading the fast vector word (0x41) while nfiq_o is high does the same. A spurious read changes no pending or in-service state.
- R7: An edge input latches pending on a rising input, and a successful vector read clears that latch. A level input is pending while its input is high and stops being pending when the input falls, with no acknowledge.
- R8: Writing ones to the force command (0x46) makes those inputs pending. Writing ones to the clear command (0x47) removes pending latches.
- R9: The core status word (0x4A) reads bit 1 = fast line asserted and bit 0 = normal line asserted.
- R10: Writing ones to 0x44 enables inputs and writing ones to 0x45 disables them. The enable word reads back at 0x43 and the pending word at 0x42. A pending but disabled input asserts no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt inputs, active high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 7 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after the read strobe |
| nirq_o | output | 1 | Normal interrupt line, active low |
| nfiq_o | output | 1 | Fast interrupt line, active low |

## Verification
The main function is driven with three kinds of input pattern. Two edge inputs at equal priority rising together show whether ties go to the lower input number and whether the equal-priority request is held off until end of service. A low-priority level input pre-empted by a high-priority one, while a middle-priority edge arrives, shows whether the in-service stack gates the line on strict priority and unwinds in the right order. Sequences of masking, forcing and clearing between the line asserting and the vector read separate a true acknowledge from a spurious return. A behavioural model in the bench follows every clock and checks both lines and all read data.

// File: rtl/avic_pkg.sv
package avic_pkg;
  localparam int DATA_W        = 32;
  localparam int REGION_LSB    = 5;
  localparam int MODE_EDGE_BIT = 4;

  localparam logic [6:0] ADDR_IVR  = 7'h40;
  localparam logic [6:0] ADDR_FVR  = 7'h41;
  localparam logic [6:0] ADDR_PEND = 7'h42;
  localparam logic [6:0] ADDR_MASK = 7'h43;
  localparam logic [6:0] ADDR_ENA  = 7'h44;
  localparam logic [6:0] ADDR_DIS  = 7'h45;
  localparam logic [6:0] ADDR_SETP = 7'h46;
  localparam logic [6:0] ADDR_CLRP = 7'h47;
  localparam logic [6:0] ADDR_EOI  = 7'h48;
  localparam logic [6:0] ADDR_SPUR = 7'h49;
  localparam logic [6:0] ADDR_CORE = 7'h4A;
endpackage

// File: rtl/avic_src_bank.sv
module avic_src_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] edge_mode_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic prev_q, lat_q, rise;
    assign rise = edge_mode_i[g] & src_i[g] & ~prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= src_i[g];
        if (rise || set_i[g])  lat_q <= 1'b1;
        else if (clr_i[g])     lat_q <= 1'b0;
      end
    end

    assign pend_o[g] = lat_q | (~edge_mode_i[g] & src_i[g]);

    // R7: a rising edge input is pending in the next cycle
    a_r7_edge_latch: assert property (@(posedge clk) disable iff (rst)
      (edge_mode_i[g] && src_i[g] && !prev_q) |=> pend_o[g]);
  end
endmodule

// File: rtl/avic_arbiter.sv
module avic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] elig_i,
  input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
  output logic               valid_o,
  output logic [IDX_W-1:0]   id_o,
  output logic [PRIO_W-1:0]  prio_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    // walk downward so that a lower index wins a tie
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (elig_i[i] && (!valid_o || prio_i[i] >= prio_o)) begin
        valid_o = 1'b1;
        id_o    = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end

  // R3: the chosen input is one that is eligible
  a_r3_winner_eligible: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> elig_i[id_o]);
endmodule

// File: rtl/avic_prio_stack.sv
module avic_prio_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] push_val_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [PRIO_W-1:0] top_o
);
  logic [PRIO_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  top_idx;

  always_ff @(posedge clk) begin
    if (push_i) mem[cnt_q[PTR_W-1:0]] <= push_val_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (push_i && !pop_i) cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
  end

  assign top_idx = cnt_q - 1'b1;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_o   = empty_o ? '0 : mem[top_idx[PTR_W-1:0]];

  // R4: strict priority nesting never needs more levels than exist
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  // R4: each new level is above the one it pre-empts
  a_r4_push_ascending: assert property (@(posedge clk) disable iff (rst)
    (push_i && !empty_o) |-> (push_val_i > top_o));
  // R5: end of service only pops a level that exists
  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
endmodule

// File: rtl/avic_top.sv
module avic_top
  import avic_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = 7,
  localparam int IDX_W      = $clog2(NUM_SRC),
  localparam int REG_W      = ADDR_W - REGION_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               nirq_o,
  output logic               nfiq_o
);
  logic [NUM_SRC-1:0] mask_q, edge_q, pend, set_vec, clr_vec, ack_vec, elig;
  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [DATA_W-1:0]  vec_mem [NUM_SRC];
  logic [DATA_W-1:0]  spur_q, rdata_q, rd_mux;
  logic               irq_q, fiq_q;

  logic [REG_W-1:0]   region;
  logic [IDX_W-1:0]   idx;
  logic               idx_ok, mode_wr, vec_wr;
  logic               ivr_rd, fvr_rd, ivr_take, fvr_take;
  logic               irq_cond, fiq_cond, eoi_wr;

  logic               arb_valid;
  logic [IDX_W-1:0]   arb_id;
  logic [PRIO_W-1:0]  arb_prio;
  logic               stk_empty, stk_full, stk_pop;
  logic [PRIO_W-1:0]  stk_top;

  // address decode
  assign region   = bus_addr_i[ADDR_W-1:REGION_LSB];
  assign idx      = bus_addr_i[IDX_W-1:0];
  assign idx_ok   = int'(bus_addr_i[REGION_LSB-1:0]) < NUM_SRC;
  assign mode_wr  = bus_wr_i && (region == REG_W'(0)) && idx_ok;
  assign vec_wr   = bus_wr_i && (region == REG_W'(1)) && idx_ok;
  assign ivr_rd   = bus_rd_i && (bus_addr_i == ADDR_W'(ADDR_IVR));
  assign fvr_rd   = bus_rd_i && (bus_addr_i == ADDR_W'(ADDR_FVR));
  assign eoi_wr   = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_EOI));

  // source latches
  assign set_vec = (bus_wr_i && bus_addr_i == ADDR_W'(ADDR_SETP)) ? bus_wdata_i[NUM_SRC-1:0] : '0;
  assign clr_vec = ((bus_wr_i && bus_addr_i == ADDR_W'(ADDR_CLRP)) ? bus_wdata_i[NUM_SRC-1:0] : '0)
                 | ack_vec;
  assign ack_vec = (ivr_take ? (NUM_SRC'(1) << arb_id) : '0) | (fvr_take ? NUM_SRC'(1) : '0);

  avic_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst), .src_i(src_i), .edge_mode_i(edge_q),
    .set_i(set_vec), .clr_i(clr_vec), .pend_o(pend)
  );

  // arbitration among inputs 1..N-1 (input 0 belongs to the fast line)
  assign elig = pend & mask_q & ~NUM_SRC'(1);

  avic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst(rst), .elig_i(elig), .prio_i(prio_q),
    .valid_o(arb_valid), .id_o(arb_id), .prio_o(arb_prio)
  );

  avic_prio_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk(clk), .rst(rst), .push_i(ivr_take), .pop_i(stk_pop),
    .push_val_i(arb_prio), .empty_o(stk_empty), .full_o(stk_full), .top_o(stk_top)
  );

  assign irq_cond = arb_valid && (stk_empty || arb_prio > stk_top);
  assign fiq_cond = pend[0] && mask_q[0];
  assign ivr_take = ivr_rd && irq_q && irq_cond;
  assign fvr_take = fvr_rd && fiq_q && fiq_cond;
  assign stk_pop  = eoi_wr && !stk_empty;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      edge_q <= '0;
      spur_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
    end else begin
      if (mode_wr) begin
        prio_q[idx] <= bus_wdata_i[PRIO_W-1:0];
        edge_q[idx] <= bus_wdata_i[MODE_EDGE_BIT];
      end
      if (bus_wr_i && bus_addr_i == ADDR_W'(ADDR_ENA)) mask_q <= mask_q | bus_wdata_i[NUM_SRC-1:0];
      if (bus_wr_i && bus_addr_i == ADDR_W'(ADDR_DIS)) mask_q <= mask_q & ~bus_wdata_i[NUM_SRC-1:0];
      if (bus_wr_i && bus_addr_i == ADDR_W'(ADDR_SPUR)) spur_q <= bus_wdata_i;
    end
  end

  // vector words, no reset so that a RAM can hold them
  always_ff @(posedge clk) begin
    if (vec_wr) vec_mem[idx] <= bus_wdata_i;
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (region == REG_W'(0)) begin
      if (idx_ok) begin
        rd_mux[PRIO_W-1:0]    = prio_q[idx];
        rd_mux[MODE_EDGE_BIT] = edge_q[idx];
      end
    end else if (region == REG_W'(1)) begin
      if (idx_ok) rd_mux = vec_mem[idx];
    end else begin
      case (bus_addr_i)
        ADDR_W'(ADDR_IVR):  rd_mux = (irq_q && irq_cond) ? vec_mem[arb_id] : spur_q;
        ADDR_W'(ADDR_FVR):  rd_mux = (fiq_q && fiq_cond) ? vec_mem[0] : spur_q;
        ADDR_W'(ADDR_PEND): rd_mux = DATA_W'(pend);
        ADDR_W'(ADDR_MASK): rd_mux = DATA_W'(mask_q);
        ADDR_W'(ADDR_SPUR): rd_mux = spur_q;
        ADDR_W'(ADDR_CORE): rd_mux = DATA_W'({fiq_q, irq_q});
        default:            rd_mux = '0;
      endcase
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= irq_cond && !ivr_rd;
      fiq_q <= fiq_cond && !fvr_rd;
      if (bus_rd_i) rdata_q <= rd_mux;
    end
  end

  assign nirq_o      = ~irq_q;
  assign nfiq_o      = ~fiq_q;
  assign bus_rdata_o = rdata_q;

  // R2: the fast line falls only for input 0
  a_r2_fiq_source0: assert property (@(posedge clk) disable iff (rst)
    $fell(nfiq_o) |-> $past(pend[0] && mask_q[0]));
  // R4: the normal line falls only above the in-service level
  a_r4_irq_above_level: assert property (@(posedge clk) disable iff (rst)
    $fell(nirq_o) |-> $past(arb_valid && (stk_empty || arb_prio > stk_top)));
  // R4: a vector read releases the normal line
  a_r4_read_releases: assert property (@(posedge clk) disable iff (rst)
    ivr_rd |=> nirq_o);
  // R6: a read with the line idle yields the spurious word
  a_r6_spurious_idle: assert property (@(posedge clk) disable iff (rst)
    (ivr_rd && !irq_q) |=> (bus_rdata_o == $past(spur_q)));
endmodule

// File: tb/avic_top_test.sv
module avic_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nirq, nfiq;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  avic_top uut (
    .clk(clk), .rst(rst), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .nirq_o(nirq), .nfiq_o(nfiq)
  );

  // ---------------- behavioural reference model ----------------
  int          m_prio [N];
  bit          m_edge [N];
  logic [31:0] m_vec  [N];
  bit   [N-1:0] m_lat, m_mask, m_prev;
  logic [31:0] m_spur, m_rdata;
  int          m_stk [$];
  bit          m_irq, m_fiq;

  always @(posedge clk) begin
    bit [N-1:0] pend, setv, clrv;
    int bi, bp;
    bit irqc, fiqc, rd_ivr, rd_fvr;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_edge[i] = 0; end
      m_lat = '0; m_mask = '0; m_prev = '0; m_spur = '0; m_rdata = '0;
      m_stk.delete(); m_irq = 0; m_fiq = 0;
    end else begin
      for (int i = 0; i < N; i++) pend[i] = m_lat[i] | (!m_edge[i] & src[i]);
      bi = -1; bp = -1;
      for (int i = 1; i < N; i++)
        if (pend[i] && m_mask[i] && m_prio[i] > bp) begin bi = i; bp = m_prio[i]; end
      irqc = (bi >= 0) && (m_stk.size() == 0 || bp > m_stk[$]);
      fiqc = pend[0] && m_mask[0];
      rd_ivr = rd && addr == 7'h40;
      rd_fvr = rd && addr == 7'h41;
      if (rd) begin
        if (addr < 7'h20)      m_rdata = {27'd0, m_edge[addr[4:0]], 1'b0, 3'(m_prio[addr[4:0]])};
        else if (addr < 7'h40) m_rdata = m_vec[addr[4:0]];
        else case (addr)
          7'h40: m_rdata = (m_irq && irqc) ? m_vec[bi] : m_spur;
          7'h41: m_rdata = (m_fiq && fiqc) ? m_vec[0] : m_spur;
          7'h42: m_rdata = pend;
          7'h43: m_rdata = m_mask;
          7'h49: m_rdata = m_spur;
          7'h4A: m_rdata = {30'd0, m_fiq, m_irq};
          default: m_rdata = '0;
        endcase
      end
      setv = '0; clrv = '0;
      if (rd_ivr && m_irq && irqc) begin clrv[bi] = 1; m_stk.push_back(bp); end
      if (rd_fvr && m_fiq && fiqc) clrv[0] = 1;
      if (wr && addr == 7'h46) setv = wdata;
      if (wr && addr == 7'h47) clrv |= wdata;
      for (int i = 0; i < N; i++) begin
        if ((m_edge[i] && src[i] && !m_prev[i]) || setv[i]) m_lat[i] = 1;
        else if (clrv[i]) m_lat[i] = 0;
      end
      if (wr) begin
        if (addr < 7'h20) begin m_prio[addr[4:0]] = wdata[2:0]; m_edge[addr[4:0]] = wdata[4]; end
        else if (addr < 7'h40) m_vec[addr[4:0]] = wdata;
        else case (addr)
          7'h44: m_mask |= wdata;
          7'h45: m_mask &= ~wdata;
          7'h48: if (m_stk.size() > 0) void'(m_stk.pop_back());
          7'h49: m_spur = wdata;
          default: ;
        endcase
      end
      m_irq = irqc && !rd_ivr;
      m_fiq = fiqc && !rd_fvr;
      m_prev = src;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (nirq !== !m_irq || nfiq !== !m_fiq || rdata !== m_rdata) begin
        errors++;
        $display("FAIL %s model: actual nirq=%b nfiq=%b rdata=%h expected nirq=%b nfiq=%b rdata=%h",
                 cur_req, nirq, nfiq, rdata, !m_irq, !m_fiq, m_rdata);
      end
    end
  end

  // ---------------- tasks (entered and left at a falling edge) ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [6:0] a, input logic [31:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic rreg(input logic [6:0] a, input string req, input logic [31:0] exp);
    rd = 1; addr = a;
    @(negedge clk);
    rd = 0;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] SPUR = 32'hDEAD_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 nirq", {31'd0, nirq}, 32'd1);
    chk("R1 nfiq", {31'd0, nfiq}, 32'd1);
    chk("R1 rdata", rdata, 32'd0);
    rreg(7'h43, "R1 mask", 32'd0);
    rreg(7'h40, "R1 spurious after reset", 32'd0);

    wreg(7'h49, SPUR);
    for (int i = 0; i < N; i++) wreg(7'(32 + i), 32'h100 + i);
    wreg(7'h00, 32'h10);      // input 0 edge
    wreg(7'h01, 32'h02);      // input 1 level prio 2
    wreg(7'h02, 32'h15);      // input 2 edge prio 5
    wreg(7'h03, 32'h15);      // input 3 edge prio 5
    wreg(7'h04, 32'h07);      // input 4 level prio 7
    wreg(7'h05, 32'h17);      // input 5 edge prio 7, left disabled
    rreg(7'h02, "R3 mode readback", 32'h15);
    wreg(7'h44, 32'h1F);
    rreg(7'h43, "R10 enable word", 32'h1F);

    // fast line from input 0 only
    cur_req = "R2";
    src[0] = 1; @(negedge clk); src[0] = 0; idle(2);
    chk("R2 nfiq low", {31'd0, nfiq}, 32'd0);
    chk("R2 nirq stays high", {31'd0, nirq}, 32'd1);
    rreg(7'h4A, "R9 core status fast", 32'h2);
    rreg(7'h41, "R2 fast vector", 32'h100);
    idle(1);
    chk("R7 fast edge cleared by ack", {31'd0, nfiq}, 32'd1);
    rreg(7'h41, "R6 fast spurious", SPUR);

    // equal-priority tie, held off until end of service
    cur_req = "R3";
    src[3:2] = 2'b11; idle(3);
    chk("R3 nirq low", {31'd0, nirq}, 32'd0);
    rreg(7'h40, "R3 tie to lower input", 32'h102);
    idle(2);
    chk("R4 equal priority held off", {31'd0, nirq}, 32'd1);
    cur_req = "R5";
    wreg(7'h48, 0); idle(2);
    chk("R5 line after end of service", {31'd0, nirq}, 32'd0);
    rreg(7'h40, "R5 second of tie", 32'h103);
    wreg(7'h48, 0); idle(2);
    chk("R5 all served", {31'd0, nirq}, 32'd1);
    src[3:2] = 2'b00; idle(1);

    // nesting
    cur_req = "R4";
    src[1] = 1; idle(3);
    rreg(7'h40, "R4 low level first", 32'h101);
    src[4] = 1; idle(3);
    chk("R4 pre-empt line", {31'd0, nirq}, 32'd0);
    rreg(7'h40, "R4 pre-empting vector", 32'h104);
    src[2] = 1; idle(3);
    chk("R4 middle priority held", {31'd0, nirq}, 32'd1);
    src[4] = 0; src[2] = 0; idle(1);
    wreg(7'h48, 0); idle(2);
    chk("R5 middle released", {31'd0, nirq}, 32'd0);
    rreg(7'h40, "R5 middle vector", 32'h102);
    wreg(7'h48, 0);
    wreg(7'h48, 0); idle(2);
    rreg(7'h40, "R7 level still pending", 32'h101);
    src[1] = 0;
    wreg(7'h48, 0); idle(2);
    chk("R7 level gone", {31'd0, nirq}, 32'd1);

    // spurious cases
    cur_req = "R6";
    rreg(7'h40, "R6 idle read", SPUR);
    src[2] = 1; idle(3); src[2] = 0;
    wreg(7'h45, 32'h4);
    rreg(7'h40, "R6 masked before read", SPUR);
    idle(1);
    chk("R10 disabled asserts nothing", {31'd0, nirq}, 32'd1);
    rreg(7'h42, "R6 pending kept after spurious", 32'h4);
    rreg(7'h43, "R10 disable cleared bit", 32'h1B);
    wreg(7'h47, 32'h4);
    rreg(7'h42, "R8 clear command", 32'h0);
    wreg(7'h44, 32'h4); idle(2);
    chk("R8 cleared stays quiet", {31'd0, nirq}, 32'd1);

    // force command
    cur_req = "R8";
    wreg(7'h46, 32'h8); idle(2);
    chk("R8 force asserts line", {31'd0, nirq}, 32'd0);
    rreg(7'h4A, "R9 core status normal", 32'h1);
    rreg(7'h40, "R8 forced vector", 32'h103);
    wreg(7'h48, 0); idle(2);
    rreg(7'h4A, "R9 core status idle", 32'h0);

    // level follows input, disabled input ignored
    cur_req = "R7";
    src[1] = 1; idle(2);
    rreg(7'h42, "R7 level pending", 32'h2);
    src[1] = 0; idle(2);
    rreg(7'h42, "R7 level drops", 32'h0);
    chk("R7 line drops without ack", {31'd0, nirq}, 32'd1);
    cur_req = "R10";
    src[5] = 1; idle(3); src[5] = 0;
    chk("R10 disabled input no line", {31'd0, nirq}, 32'd1);
    rreg(7'h42, "R10 disabled still pending", 32'h20);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule